// File: doc/BRIEF.md
# Transition-Pulse Encoder with Refresh

This block drives the sending half of a one-bit isolated link. A single logic input is brought into the clock domain and watched for level changes. Each change becomes a short pulse on one of two wires. `pulse_set` reports that the input is now high, and `pulse_rst` reports that it is now low. A receiving latch on the far side of the barrier can then rebuild the level from these pulses alone.

While the input holds still, a timer counts idle cycles. Once the idle window has passed, the encoder sends the present level again on the matching wire. It then repeats that refresh at a fixed period until the input moves, so a receiver that missed a pulse or was just powered up settles on the right level. Every duration is a count of system clock cycles set by a parameter. An enable input stands for "sending-side supply present". When it is low, the block sends nothing at all.

Top module: `xfer_pulse_encoder`

## Requirements
- R1: While `rst` is high, both pulse outputs are low in the cycle after each clock edge, so no pulse leaves the block during reset.
- R2: A low-to-high change on `din` makes `pulse_set` rise on the third rising clock edge after the change. Two edges are for the synchroniser and one for the registered output. `pulse_rst` stays low.
- R3: A high-to-low change on `din` makes `pulse_rst` rise on the third rising clock edge after the change, and `pulse_set` stays low.
- R4: `pulse_set` and `pulse_rst` are never high in the same cycle.
- R5: If no input change follows an edge pulse, the first refresh pulse starts exactly `IDLE_CYC` cycles after that edge pulse started. It is sent on `pulse_set` when the level is high and on `pulse_rst` when it is low.
- R6: While the input stays idle, further refresh pulses for the current level start every `REF_CYC` cycles after the previous one.
- R7: Every input change restarts the idle timer. If changes come closer together than `IDLE_CYC` cycles, only edge pulses are sent and no refresh pulse appears.
- R8: Input changes spaced at the minimum data pulse width of 10 cycles each produce exactly one pulse of the correct polarity, with none lost.
- R9: While `en` is low, both outputs are low and input changes produce no pulse. When `en` returns high with the input steady, the first refresh pulse is sampled `IDLE_CYC` clock edges after the enable change.
- R10: Every pulse, edge or refresh, stays high for exactly `PULSE_W` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sending-side supply present; low stops all pulse activity |
| din | input | 1 | Asynchronous logic input to be carried across the link |
| pulse_set | output | 1 | Registered pulse meaning "input is high" |
| pulse_rst | output | 1 | Registered pulse meaning "input is low" |

## Verification
An input change driven between clock edges shows up as a pulse start after the third rising edge. A refresh starts exactly `IDLE_CYC` edges after the edge pulse it follows, and later refreshes come `REF_CYC` edges apart. After an enable change, the first refresh is due `IDLE_CYC` edges later. The bench drives every input at the falling edge and counts falling-edge samples from that point. It records the sample index at which each pulse starts and compares the gap with these fixed counts, so a one-cycle slip in either direction is reported. Window tests count pulse starts over a fixed number of cycles. This catches lost edges, extra refreshes and wrong polarity.

// File: rtl/xpe_pkg.sv
package xpe_pkg;
  typedef enum logic [1:0] {
    XPE_IDLE = 2'd0,
    XPE_HIGH = 2'd1,
    XPE_LOW  = 2'd2
  } xpe_kind_t;

  function automatic xpe_kind_t xpe_kind_of(input logic req, input logic lvl);
    if (!req)     return XPE_IDLE;
    else if (lvl) return XPE_HIGH;
    else          return XPE_LOW;
  endfunction
endpackage

// File: rtl/xpe_sync.sv
module xpe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic lvl,
  output logic chg
);
  logic [STAGES-1:0] stg;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= 1'b0;
          else     stg[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= 1'b0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= stg[STAGES-1];
  end

  assign lvl = stg[STAGES-1];
  assign chg = stg[STAGES-1] ^ prev;
endmodule

// File: rtl/xpe_idle_timer.sv
module xpe_idle_timer #(
  parameter int IDLE_CYC = 100,
  parameter int REF_CYC  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic chg,
  output logic fire
);
  localparam int MAXC = (IDLE_CYC > REF_CYC) ? IDLE_CYC : REF_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYC - 1);
  localparam logic [CW-1:0] REF_LAST  = CW'(REF_CYC - 1);

  logic [CW-1:0] cnt;
  logic          in_ref;
  logic [CW-1:0] target;

  assign target = in_ref ? REF_LAST : IDLE_LAST;
  assign fire   = en && !rst && !chg && (cnt == target);

  always_ff @(posedge clk) begin
    if (rst || !en || chg) begin
      cnt    <= '0;
      in_ref <= 1'b0;
    end else if (cnt == target) begin
      cnt    <= '0;
      in_ref <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/xpe_pulse_gen.sv
module xpe_pulse_gen
  import xpe_pkg::*;
#(
  parameter int PULSE_W = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic req,
  input  logic lvl,
  output logic p_hi,
  output logic p_lo
);
  localparam int WW = $clog2(PULSE_W + 1);
  localparam logic [WW-1:0] W_LAST = WW'(PULSE_W - 1);

  logic [WW-1:0] wcnt;
  xpe_kind_t     kind;

  assign kind = xpe_kind_of(req, lvl);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      p_hi <= 1'b0;
      p_lo <= 1'b0;
      wcnt <= '0;
    end else if (kind != XPE_IDLE) begin
      p_hi <= (kind == XPE_HIGH);
      p_lo <= (kind == XPE_LOW);
      wcnt <= W_LAST;
    end else if (wcnt != '0) begin
      wcnt <= wcnt - 1'b1;
    end else begin
      p_hi <= 1'b0;
      p_lo <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_pulse_encoder.sv
module xfer_pulse_encoder #(
  parameter int PULSE_W  = 1,
  parameter int IDLE_CYC = 100,
  parameter int REF_CYC  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic pulse_set,
  output logic pulse_rst
);
  logic lvl;
  logic chg;
  logic fire;
  logic req;

  xpe_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (din),
    .lvl     (lvl),
    .chg     (chg)
  );

  xpe_idle_timer #(.IDLE_CYC(IDLE_CYC), .REF_CYC(REF_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .chg  (chg),
    .fire (fire)
  );

  assign req = chg | fire;

  xpe_pulse_gen #(.PULSE_W(PULSE_W)) u_pgen (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .req  (req),
    .lvl  (lvl),
    .p_hi (pulse_set),
    .p_lo (pulse_rst)
  );
endmodule

// File: rtl/xfer_pulse_encoder_chk.sv
module xfer_pulse_encoder_chk #(
  parameter int PULSE_W = 1
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic din,
  input logic pulse_set,
  input logic pulse_rst
);
  localparam int RW = $clog2(PULSE_W + 2) + 1;

  logic [2:0]    quiet;
  logic [RW-1:0] run_s;
  logic [RW-1:0] run_r;

  always_ff @(posedge clk) begin
    if (rst || !en)      quiet <= '0;
    else if (quiet != 7) quiet <= quiet + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_s <= '0;
      run_r <= '0;
    end else begin
      run_s <= pulse_set ? ((run_s == '1) ? run_s : run_s + 1'b1) : '0;
      run_r <= pulse_rst ? ((run_r == '1) ? run_r : run_r + 1'b1) : '0;
    end
  end

  // R4
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pulse_set && pulse_rst));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pulse_set && !pulse_rst));

  // R9
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pulse_set && !pulse_rst));

  // R10
  width_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(run_s) <= PULSE_W) && (int'(run_r) <= PULSE_W));

  // R2
  rise_map_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 3'd5 && $past(din, 3) && !$past(din, 4)) |-> (pulse_set && !pulse_rst));

  // R3
  fall_map_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 3'd5 && !$past(din, 3) && $past(din, 4)) |-> (pulse_rst && !pulse_set));
endmodule

bind xfer_pulse_encoder xfer_pulse_encoder_chk #(.PULSE_W(PULSE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .din       (din),
  .pulse_set (pulse_set),
  .pulse_rst (pulse_rst)
);

// File: tb/xfer_pulse_encoder_test.sv
module xfer_pulse_encoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW   = 2;
  localparam int IDLE = 40;
  localparam int REF  = 25;
  localparam int LAT  = 3;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b1;
  logic din = 1'b0;
  logic pulse_set;
  logic pulse_rst;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_pulse_encoder #(.PULSE_W(PW), .IDLE_CYC(IDLE), .REF_CYC(REF)) uut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .din       (din),
    .pulse_set (pulse_set),
    .pulse_rst (pulse_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // Wait for the next pulse start; report its sample index, kind and width.
  task automatic wait_start(input int maxc, output int at, output bit is_set,
                            output int width, output bit found);
    bit was = pulse_set | pulse_rst;
    found = 1'b0; at = -1; is_set = 1'b0; width = 0;
    for (int i = 0; i < maxc && !found; i++) begin
      step(1);
      if ((pulse_set | pulse_rst) && !was) begin
        found = 1'b1;
        at = cyc;
        is_set = pulse_set;
      end
      was = pulse_set | pulse_rst;
    end
    if (found) begin
      width = 1;
      for (int i = 0; i < PW + 4; i++) begin
        step(1);
        if (is_set ? pulse_set : pulse_rst) width++;
        else break;
      end
    end
  endtask

  task automatic count_starts(input int n, output int ns, output int nr);
    bit ws = pulse_set;
    bit wr = pulse_rst;
    ns = 0; nr = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (pulse_set && !ws) ns++;
      if (pulse_rst && !wr) nr++;
      chk(!(pulse_set && pulse_rst), "R4", int'(pulse_set && pulse_rst), 0);
      ws = pulse_set;
      wr = pulse_rst;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; din = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1);
      din = ~din;
      chk(!pulse_set && !pulse_rst, "R1", int'({pulse_set, pulse_rst}), 0);
    end
    din = 1'b0;
    step(3);
    rst = 1'b0;
    step(3);
    chk(!pulse_set && !pulse_rst, "R1", int'({pulse_set, pulse_rst}), 0);
  endtask

  task automatic t_edge_and_refresh(input bit v);
    int t0, at, w, at2, at3;
    bit s, f;
    string re;
    re = v ? "R2" : "R3";
    t0 = cyc;
    din = v;
    wait_start(LAT + 4, at, s, w, f);
    chk(f && (at - t0) == LAT, re, at - t0, LAT);
    chk(s == v, re, int'(s), int'(v));
    chk(w == PW, "R10", w, PW);
    wait_start(IDLE + 5, at2, s, w, f);
    chk(f && (at2 - at) == IDLE, "R5", at2 - at, IDLE);
    chk(s == v, "R5", int'(s), int'(v));
    chk(w == PW, "R10", w, PW);
    wait_start(REF + 5, at3, s, w, f);
    chk(f && (at3 - at2) == REF, "R6", at3 - at2, REF);
    chk(s == v, "R6", int'(s), int'(v));
    wait_start(REF + 5, at2, s, w, f);
    chk(f && (at2 - at3) == REF, "R6", at2 - at3, REF);
  endtask

  task automatic t_restart();
    int ns, nr;
    for (int k = 0; k < 6; k++) begin
      din = ~din;
      count_starts(30, ns, nr);
      chk(ns + nr == 1, "R7", ns + nr, 1);
      chk((din ? ns : nr) == 1, "R7", din ? ns : nr, 1);
    end
  endtask

  task automatic t_min_spacing();
    int ns, nr, tot_s, tot_r;
    tot_s = 0; tot_r = 0;
    for (int k = 0; k < 20; k++) begin
      din = ~din;
      count_starts(10, ns, nr);
      tot_s += ns; tot_r += nr;
      chk((din ? ns : nr) == 1 && (ns + nr) == 1, "R8", din ? ns : nr, 1);
    end
    chk(tot_s == 10, "R8", tot_s, 10);
    chk(tot_r == 10, "R8", tot_r, 10);
  endtask

  task automatic t_enable();
    int ns, nr, t0, at, w;
    bit s, f;
    en = 1'b0;
    step(1);
    chk(!pulse_set && !pulse_rst, "R9", int'({pulse_set, pulse_rst}), 0);
    for (int k = 0; k < 6; k++) begin
      din = ~din;
      count_starts(10, ns, nr);
      chk(ns + nr == 0 && !pulse_set && !pulse_rst, "R9", ns + nr, 0);
    end
    din = 1'b1;
    count_starts(IDLE + 10, ns, nr);
    chk(ns + nr == 0, "R9", ns + nr, 0);
    t0 = cyc;
    en = 1'b1;
    wait_start(IDLE + 5, at, s, w, f);
    chk(f && (at - t0) == IDLE, "R9", at - t0, IDLE);
    chk(s == 1'b1, "R9", int'(s), 1);
  endtask

  initial begin
    t_reset();
    t_edge_and_refresh(1'b1);
    t_edge_and_refresh(1'b0);
    t_restart();
    t_min_spacing();
    t_enable();
    t_reset();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    finish_run();
  end
endmodule